// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block translates a linear address into a physical address by walking a tree of 64-bit paging entries held in memory. A translate request carries the linear address and the kind of access: read, write or instruction fetch. The walker takes the root-table base register and the current level count, and reads one entry per level through a simple request/response memory port. It forms each entry address from the table frame of the previous entry and the 9-bit index field of the linear address that belongs to that level.

A walk has either four levels, which cover 48-bit linear addresses, or five levels, which cover 57-bit linear addresses. A small mode register holds the level count. Software may change it only while paging is off. A walk stops early when it reaches a 1 GB or 2 MB large-page entry, and it stops with a fault when it reads an entry that is not present. Along the way the walker combines the writable, user and no-execute bits of every entry it reads. It returns those combined rights with the physical address, a page-size code and a fault flag. The fault flag also covers a write to a read-only page and a fetch from a no-execute page.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `res_valid` and `mem_rd_valid` are 0, and `mode_five` is 0, meaning four-level mode.
- R2: In four-level mode, the first entry is read at `{root_base[51:12], laddr[47:39], 3'b000}`. Each later read uses bits 51:12 of the entry just returned, followed by the index for the next lower level (`laddr[38:30]`, then `laddr[29:21]`, then `laddr[20:12]`) and three zero bits. A walk that ends at level 1 makes 4 reads, returns `res_paddr = {leaf[51:12], laddr[11:0]}`, and reports `res_size` 0 for a 4 KB page.
- R3: In five-level mode, the first read is at `{root_base[51:12], laddr[56:48], 3'b000}`, and a walk to level 1 makes 5 reads.
- R4: A present entry with bit 7 set at level 3 ends the walk as a 1 GB page: `res_paddr = {entry[51:30], laddr[29:0]}` and `res_size` is 2. At level 2 the same bit ends the walk as a 2 MB page: `res_paddr = {entry[51:21], laddr[20:0]}` and `res_size` is 1.
- R5: Bit 7 set in an entry at the top level (level 4 or level 5) is ignored, and the walk goes on to the next level.
- R6: An entry with bit 0 (present) clear ends the walk with `res_fault` set and `res_paddr` equal to 0. No further reads are issued for that walk.
- R7: The result rights are combined over every entry read, the final one included. `res_writable` is the AND of bit 1, `res_user` is the AND of bit 2, and `res_nx` is the OR of bit 63.
- R8: `req_kind` is encoded as 0 for read, 1 for write and 2 for fetch. A write whose combined writable bit is 0 faults, and so does a fetch whose combined no-execute bit is 1. A fault of either kind forces `res_paddr` to 0. A read never faults on rights.
- R9: A mode change (`mode_req_valid` with `mode_req_five`) made while `paging_en` is 0 shows on `mode_five` in the next cycle. A mode change made while `paging_en` is 1 is refused, and the mode stays as it was.
- R10: A walk uses the mode held in the register in the cycle the walk is accepted. A mode change accepted in that same cycle applies from the next walk on.
- R11: At most one memory read is outstanding. `mem_rd_valid` is a one-cycle pulse, and the next read is issued only after `mem_rsp_valid` returns. A response that arrives when no read is pending is ignored, and so is a request made while `req_ready` is 0.
- R12: In four-level mode, linear-address bits 56:48 have no effect on any read address or on the result.
- R13: `res_valid` is a one-cycle pulse, and `req_ready` is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | Paging enabled; blocks mode changes while set |
| mode_req_valid | input | 1 | Request to change the level mode |
| mode_req_five | input | 1 | Requested mode: 1 for five levels, 0 for four levels |
| mode_five | output | 1 | Current mode: 1 for five levels |
| root_base | input | 52 | Root-table base; bits 51:12 are used |
| req_valid | input | 1 | Translate request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_laddr | input | 57 | Linear address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| mem_rd_valid | output | 1 | Entry read request pulse |
| mem_rd_addr | output | 52 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Not-present entry or rights violation |
| res_paddr | output | 52 | Physical address; 0 on a fault |
| res_size | output | 2 | Page size: 0 for 4 KB, 1 for 2 MB, 2 for 1 GB |
| res_writable | output | 1 | Combined writable right |
| res_user | output | 1 | Combined user right |
| res_nx | output | 1 | Combined no-execute right |

## Verification
A mode change and the acceptance of a walk can fall in the same clock edge. The bench provokes this by raising `req_valid` together with `mode_req_valid` while paging is off. It then judges the outcome from the number of reads the walk makes: four, because the walk uses the old mode. It also checks that `mode_five` reads 1 afterwards, and that the next walk makes five reads, with its first address built from bits 56:48. A stray memory response sent while the walker is idle, and a second request made in the middle of a walk, are used to show that neither one disturbs the walk that follows.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WAIT = 1'b1
  } walk_state_e;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/ptw_mode_reg.sv
module ptw_mode_reg (
  input  logic clk,
  input  logic rst,
  input  logic paging_en,
  input  logic chg_valid,
  input  logic chg_five,
  output logic five_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      five_q <= 1'b0;
    end else if (chg_valid && !paging_en) begin
      five_q <= chg_five;
    end
  end

  // R9: while paging is on, the level mode must not move
  assert_mode_refused_R9: assert property (@(posedge clk) disable iff (rst)
    paging_en |=> (five_q == $past(five_q)));

endmodule

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int LA_W    = 57,
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 12,
  parameter int MAX_LVL = 5,
  parameter int LVL_W   = 3
) (
  input  logic [LA_W-1:0]  laddr,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] slice [1:MAX_LVL];

  for (genvar g = 1; g <= MAX_LVL; g++) begin : g_slice
    assign slice[g] = laddr[OFF_W + IDX_W*(g-1) +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 1; k <= MAX_LVL; k++) begin
      if (lvl == LVL_W'(k)) idx = slice[k];
    end
  end

endmodule

// File: rtl/ptw_rights.sv
module ptw_rights (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic upd,
  input  logic ent_w,
  input  logic ent_u,
  input  logic ent_nx,
  output logic cmb_w,
  output logic cmb_u,
  output logic cmb_nx
);

  logic acc_w, acc_u, acc_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_w  <= 1'b1;
      acc_u  <= 1'b1;
      acc_nx <= 1'b0;
    end else if (clr) begin
      acc_w  <= 1'b1;
      acc_u  <= 1'b1;
      acc_nx <= 1'b0;
    end else if (upd) begin
      acc_w  <= cmb_w;
      acc_u  <= cmb_u;
      acc_nx <= cmb_nx;
    end
  end

  assign cmb_w  = acc_w & ent_w;
  assign cmb_u  = acc_u & ent_u;
  assign cmb_nx = acc_nx | ent_nx;

  // R7: a lost write right stays lost until the next walk starts
  assert_w_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (!acc_w && !clr) |=> !acc_w);

  // R7: a no-execute mark stays until the next walk starts
  assert_nx_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_nx && !clr) |=> acc_nx);

endmodule

// File: rtl/ptw_leaf_addr.sv
module ptw_leaf_addr #(
  parameter int PA_W  = 52,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12
) (
  input  logic [PA_W-1:OFF_W]           frame,
  input  logic [OFF_W+2*IDX_W-1:0]      low_la,
  input  ptw_pkg::pg_size_e             size,
  output logic [PA_W-1:0]               paddr
);

  localparam int B2M = OFF_W + IDX_W;
  localparam int B1G = OFF_W + 2*IDX_W;

  always_comb begin
    unique case (size)
      ptw_pkg::PG_1G: paddr = {frame[PA_W-1:B1G], low_la[B1G-1:0]};
      ptw_pkg::PG_2M: paddr = {frame[PA_W-1:B2M], low_la[B2M-1:0]};
      default:        paddr = {frame[PA_W-1:OFF_W], low_la[OFF_W-1:0]};
    endcase
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W    = 52,
  parameter int ENT_W   = 64,
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 12,
  parameter int MAX_LVL = 5,
  parameter int LA_W    = OFF_W + IDX_W*MAX_LVL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             paging_en,
  input  logic             mode_req_valid,
  input  logic             mode_req_five,
  output logic             mode_five,
  input  logic [PA_W-1:0]  root_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LA_W-1:0]  req_laddr,
  input  logic [1:0]       req_kind,
  output logic             mem_rd_valid,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             res_valid,
  output logic             res_fault,
  output logic [PA_W-1:0]  res_paddr,
  output logic [1:0]       res_size,
  output logic             res_writable,
  output logic             res_user,
  output logic             res_nx
);
  import ptw_pkg::*;

  localparam int LVL_W   = $clog2(MAX_LVL + 1);
  localparam int ENT_LG  = $clog2(ENT_W / 8);
  localparam int B1G     = OFF_W + 2*IDX_W;
  localparam int P_BIT   = 0;
  localparam int W_BIT   = 1;
  localparam int U_BIT   = 2;
  localparam int PS_BIT  = 7;
  localparam int NX_BIT  = ENT_W - 1;
  localparam logic [LVL_W-1:0] LVL_1G = LVL_W'(3);
  localparam logic [LVL_W-1:0] LVL_2M = LVL_W'(2);
  localparam logic [LVL_W-1:0] LVL_PT = LVL_W'(1);

  walk_state_e      st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [LA_W-1:0]  laddr_q;
  acc_kind_e        kind_q;

  logic [LVL_W-1:0] top_lvl;
  logic [IDX_W-1:0] start_idx, next_idx;
  logic             take, present, is_1g, is_2m, is_leaf, done, descend, start;
  logic             cmb_w, cmb_u, cmb_nx, rights_bad;
  pg_size_e         leaf_size;
  logic [PA_W-1:0]  leaf_paddr;
  logic             unused_bits;

  ptw_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .paging_en (paging_en),
    .chg_valid (mode_req_valid),
    .chg_five  (mode_req_five),
    .five_q    (mode_five)
  );

  assign top_lvl   = mode_five ? LVL_W'(MAX_LVL) : LVL_W'(MAX_LVL - 1);
  assign req_ready = (st_q == S_IDLE);
  assign start     = req_ready && req_valid;

  ptw_index_sel #(.LA_W(LA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W))
    u_idx_start (.laddr(req_laddr), .lvl(top_lvl), .idx(start_idx));

  ptw_index_sel #(.LA_W(LA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W))
    u_idx_next (.laddr(laddr_q), .lvl(lvl_q - LVL_W'(1)), .idx(next_idx));

  // response decode
  assign take    = (st_q == S_WAIT) && mem_rsp_valid && !mem_rd_valid;
  assign present = mem_rsp_data[P_BIT];
  assign is_1g   = (lvl_q == LVL_1G) && mem_rsp_data[PS_BIT];
  assign is_2m   = (lvl_q == LVL_2M) && mem_rsp_data[PS_BIT];
  assign is_leaf = (lvl_q == LVL_PT) || is_1g || is_2m;
  assign done    = take && (!present || is_leaf);
  assign descend = take && present && !is_leaf;

  always_comb begin
    if (is_1g)      leaf_size = PG_1G;
    else if (is_2m) leaf_size = PG_2M;
    else            leaf_size = PG_4K;
  end

  ptw_leaf_addr #(.PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_leaf (
    .frame  (mem_rsp_data[PA_W-1:OFF_W]),
    .low_la (laddr_q[B1G-1:0]),
    .size   (leaf_size),
    .paddr  (leaf_paddr)
  );

  ptw_rights u_rights (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .upd    (descend),
    .ent_w  (mem_rsp_data[W_BIT]),
    .ent_u  (mem_rsp_data[U_BIT]),
    .ent_nx (mem_rsp_data[NX_BIT]),
    .cmb_w  (cmb_w),
    .cmb_u  (cmb_u),
    .cmb_nx (cmb_nx)
  );

  assign rights_bad = ((kind_q == ACC_WRITE) && !cmb_w) ||
                      ((kind_q == ACC_FETCH) && cmb_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= S_IDLE;
      lvl_q        <= '0;
      laddr_q      <= '0;
      kind_q       <= ACC_READ;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      res_valid    <= 1'b0;
      res_fault    <= 1'b0;
      res_paddr    <= '0;
      res_size     <= 2'd0;
      res_writable <= 1'b0;
      res_user     <= 1'b0;
      res_nx       <= 1'b0;
    end else begin
      mem_rd_valid <= 1'b0;
      res_valid    <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (req_valid) begin
            laddr_q      <= req_laddr;
            kind_q       <= acc_kind_e'(req_kind);
            lvl_q        <= top_lvl;
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= {root_base[PA_W-1:OFF_W], start_idx, ENT_LG'(0)};
            st_q         <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (descend) begin
            lvl_q        <= lvl_q - LVL_W'(1);
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= {mem_rsp_data[PA_W-1:OFF_W], next_idx, ENT_LG'(0)};
          end else if (done) begin
            res_valid    <= 1'b1;
            res_fault    <= !present || rights_bad;
            res_paddr    <= (!present || rights_bad) ? '0 : leaf_paddr;
            res_size     <= leaf_size;
            res_writable <= cmb_w;
            res_user     <= cmb_u;
            res_nx       <= cmb_nx;
            st_q         <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign unused_bits = ^{root_base[OFF_W-1:0], mem_rsp_data[PS_BIT-1:U_BIT+1],
                         mem_rsp_data[OFF_W-1:PS_BIT+1], mem_rsp_data[NX_BIT-1:PA_W]};

  // R11: a read request lasts one cycle and is never back to back
  assert_single_read_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |=> !mem_rd_valid);

  // R11: no new translate is accepted while a read is in flight
  assert_busy_read_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  // R13: result is a single-cycle pulse
  assert_result_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R6: a faulted result carries no address
  assert_fault_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> (res_paddr == '0));

  // R2: a waiting walk is always at a legal level
  assert_level_range_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_WAIT) |-> (lvl_q >= LVL_PT && lvl_q <= LVL_W'(MAX_LVL)));

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        paging_en, mode_req_valid, mode_req_five, mode_five;
  logic [51:0] root_base;
  logic        req_valid, req_ready;
  logic [56:0] req_laddr;
  logic [1:0]  req_kind;
  logic        mem_rd_valid;
  logic [51:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid, res_fault, res_writable, res_user, res_nx;
  logic [51:0] res_paddr;
  logic [1:0]  res_size;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .paging_en(paging_en), .mode_req_valid(mode_req_valid),
    .mode_req_five(mode_req_five), .mode_five(mode_five), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr), .req_kind(req_kind),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
    .res_paddr(res_paddr), .res_size(res_size), .res_writable(res_writable),
    .res_user(res_user), .res_nx(res_nx)
  );

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int overlap_err = 0;
  int extra_res = 0;
  logic stray_go = 1'b0;
  logic [51:0] rd_addrs [8];
  logic [63:0] mem [logic [51:0]];

  // captured result
  logic        g_fault, g_w, g_u, g_nx, g_ready, g_after;
  logic [51:0] g_paddr;
  logic [1:0]  g_size;

  localparam logic [8:0]  I5 = 9'd3, I4 = 9'd1, I3 = 9'd2, I2 = 9'd5, I1 = 9'd7;
  localparam logic [11:0] OFS = 12'hABC;
  localparam logic [56:0] LA = {I5, I4, I3, I2, I1, OFS};
  localparam logic [51:0] ROOT4 = 52'h0_0000_0001_0000;
  localparam logic [51:0] T3    = 52'h0_0000_0002_0000;
  localparam logic [51:0] T2    = 52'h0_0000_0003_0000;
  localparam logic [51:0] T1    = 52'h0_0000_0004_0000;
  localparam logic [51:0] ROOT5 = 52'h0_0000_0006_0000;
  localparam logic [51:0] PG    = 52'h0_0012_3456_7000;
  localparam logic [51:0] G1    = 52'h0_00C0_0000_0000;
  localparam logic [51:0] M2    = 52'h0_0000_7A00_0000;

  function automatic logic [51:0] ea(logic [51:0] base, logic [8:0] idx);
    return {base[51:12], idx, 3'b000};
  endfunction

  function automatic logic [63:0] mkent(logic [51:0] base, logic nx, logic ps,
                                        logic u, logic w, logic p);
    logic [63:0] e = '0;
    e[51:12] = base[51:12];
    e[63] = nx; e[7] = ps; e[2] = u; e[1] = w; e[0] = p;
    return e;
  endfunction

  task automatic base_tables();
    mem.delete();
    mem[ea(ROOT5, I5)] = mkent(ROOT4, 0, 0, 1, 1, 1);
    mem[ea(ROOT4, I4)] = mkent(T3, 0, 0, 1, 1, 1);
    mem[ea(T3, I3)]    = mkent(T2, 0, 0, 1, 1, 1);
    mem[ea(T2, I2)]    = mkent(T1, 0, 0, 1, 1, 1);
    mem[ea(T1, I1)]    = mkent(PG, 0, 0, 1, 1, 1);
  endtask

  task automatic chk(input string rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory responder: one response LAT cycles after each request
  initial begin
    int cnt;
    logic [51:0] a;
    cnt = -1;
    a = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (stray_go) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mkent(PG, 0, 0, 1, 1, 1);
        stray_go = 1'b0;
      end
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(a) ? mem[a] : 64'd0;
        cnt = -1;
      end else if (cnt > 0) begin
        cnt--;
      end
      if (mem_rd_valid) begin
        if (cnt >= 0) overlap_err++;
        if (rd_count < 8) rd_addrs[rd_count] = mem_rd_addr;
        rd_count++;
        a = mem_rd_addr;
        cnt = LAT - 1;
      end
    end
  end

  task automatic walk(input logic [56:0] la, input logic [1:0] kind,
                      input bit with_mode, input bit poke);
    int t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_count = 0;
    req_laddr = la;
    req_kind = kind;
    req_valid = 1'b1;
    if (with_mode) begin
      mode_req_valid = 1'b1;
      mode_req_five = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    mode_req_valid = 1'b0;
    t = 0;
    while (!res_valid && t < 200) begin
      if (poke && t == 1) req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      t++;
    end
    if (t >= 200) begin
      errors++;
      $display("FAIL R13 result never arrived actual 0 expected 1");
    end
    g_fault = res_fault; g_paddr = res_paddr; g_size = res_size;
    g_w = res_writable; g_u = res_user; g_nx = res_nx; g_ready = req_ready;
    @(negedge clk);
    g_after = res_valid;
  endtask

  task automatic t_reset();
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    chk("R1", "res_valid", 64'(res_valid), 64'd0);
    chk("R1", "mem_rd_valid", 64'(mem_rd_valid), 64'd0);
    chk("R1", "mode_five", 64'(mode_five), 64'd0);
  endtask

  task automatic t_four_4k();
    base_tables();
    root_base = ROOT4;
    walk(LA, 2'd0, 0, 0);
    chk("R2", "read count", 64'(rd_count), 64'd4);
    chk("R2", "first addr", 64'(rd_addrs[0]), 64'(ea(ROOT4, I4)));
    chk("R2", "third addr", 64'(rd_addrs[2]), 64'(ea(T2, I2)));
    chk("R2", "last addr", 64'(rd_addrs[3]), 64'(ea(T1, I1)));
    chk("R2", "paddr", 64'(g_paddr), 64'({PG[51:12], OFS}));
    chk("R2", "size", 64'(g_size), 64'd0);
    chk("R2", "fault", 64'(g_fault), 64'd0);
    chk("R13", "ready with result", 64'(g_ready), 64'd1);
    chk("R13", "pulse length", 64'(g_after), 64'd0);
  endtask

  task automatic t_upper_ignored();
    base_tables();
    root_base = ROOT4;
    walk({9'h1FF, LA[47:0]}, 2'd0, 0, 0);
    chk("R12", "first addr", 64'(rd_addrs[0]), 64'(ea(ROOT4, I4)));
    chk("R12", "paddr", 64'(g_paddr), 64'({PG[51:12], OFS}));
  endtask

  task automatic t_large();
    base_tables();
    mem[ea(T3, I3)] = mkent(G1, 0, 1, 1, 1, 1);
    walk(LA, 2'd0, 0, 0);
    chk("R4", "1G reads", 64'(rd_count), 64'd2);
    chk("R4", "1G paddr", 64'(g_paddr), 64'({G1[51:30], LA[29:0]}));
    chk("R4", "1G size", 64'(g_size), 64'd2);
    base_tables();
    mem[ea(T2, I2)] = mkent(M2, 0, 1, 1, 1, 1);
    walk(LA, 2'd0, 0, 0);
    chk("R4", "2M reads", 64'(rd_count), 64'd3);
    chk("R4", "2M paddr", 64'(g_paddr), 64'({M2[51:21], LA[20:0]}));
    chk("R4", "2M size", 64'(g_size), 64'd1);
  endtask

  task automatic t_ps_top();
    base_tables();
    mem[ea(ROOT4, I4)] = mkent(T3, 0, 1, 1, 1, 1);
    walk(LA, 2'd0, 0, 0);
    chk("R5", "read count", 64'(rd_count), 64'd4);
    chk("R5", "size", 64'(g_size), 64'd0);
    chk("R5", "paddr", 64'(g_paddr), 64'({PG[51:12], OFS}));
  endtask

  task automatic t_not_present();
    base_tables();
    mem[ea(T2, I2)] = mkent(T1, 0, 0, 1, 1, 0);
    walk(LA, 2'd0, 0, 0);
    repeat (6) @(negedge clk);
    chk("R6", "fault", 64'(g_fault), 64'd1);
    chk("R6", "paddr", 64'(g_paddr), 64'd0);
    chk("R6", "reads stop", 64'(rd_count), 64'd3);
  endtask

  task automatic t_rights();
    base_tables();
    mem[ea(T3, I3)] = mkent(T2, 0, 0, 1, 0, 1);
    mem[ea(ROOT4, I4)] = mkent(T3, 0, 0, 0, 1, 1);
    walk(LA, 2'd0, 0, 0);
    chk("R7", "writable", 64'(g_w), 64'd0);
    chk("R7", "user", 64'(g_u), 64'd0);
    chk("R8", "read no fault", 64'(g_fault), 64'd0);
    walk(LA, 2'd1, 0, 0);
    chk("R8", "write fault", 64'(g_fault), 64'd1);
    chk("R8", "write fault paddr", 64'(g_paddr), 64'd0);
    base_tables();
    mem[ea(T1, I1)] = mkent(PG, 1, 0, 1, 1, 1);
    walk(LA, 2'd0, 0, 0);
    chk("R7", "nx from leaf", 64'(g_nx), 64'd1);
    chk("R7", "writable kept", 64'(g_w), 64'd1);
    walk(LA, 2'd2, 0, 0);
    chk("R8", "fetch fault", 64'(g_fault), 64'd1);
    walk(LA, 2'd1, 0, 0);
    chk("R8", "write ok", 64'(g_fault), 64'd0);
  endtask

  task automatic t_mode_refused();
    paging_en = 1'b1;
    @(negedge clk);
    mode_req_valid = 1'b1;
    mode_req_five = 1'b1;
    @(negedge clk);
    mode_req_valid = 1'b0;
    @(negedge clk);
    chk("R9", "refused while paging", 64'(mode_five), 64'd0);
    paging_en = 1'b0;
  endtask

  task automatic t_same_cycle();
    base_tables();
    root_base = ROOT4;
    walk(LA, 2'd0, 1, 0);
    chk("R10", "old mode reads", 64'(rd_count), 64'd4);
    chk("R10", "paddr", 64'(g_paddr), 64'({PG[51:12], OFS}));
    chk("R9", "accepted while off", 64'(mode_five), 64'd1);
    root_base = ROOT5;
    walk(LA, 2'd0, 0, 0);
    chk("R3", "five reads", 64'(rd_count), 64'd5);
    chk("R3", "first addr", 64'(rd_addrs[0]), 64'(ea(ROOT5, I5)));
    chk("R3", "paddr", 64'(g_paddr), 64'({PG[51:12], OFS}));
  endtask

  task automatic t_stray_and_busy();
    base_tables();
    @(negedge clk);
    stray_go = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "stray ignored, idle", 64'(req_ready), 64'd1);
    walk(LA, 2'd0, 0, 1);
    chk("R11", "busy poke paddr", 64'(g_paddr), 64'({PG[51:12], OFS}));
    chk("R11", "reads", 64'(rd_count), 64'd5);
    extra_res = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (res_valid) extra_res++;
    end
    chk("R11", "no extra walk reads", 64'(rd_count), 64'd5);
    chk("R11", "no extra result", 64'(extra_res), 64'd0);
    chk("R11", "overlapping reads", 64'(overlap_err), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    paging_en = 1'b0;
    mode_req_valid = 1'b0;
    mode_req_five = 1'b0;
    root_base = ROOT4;
    req_valid = 1'b0;
    req_laddr = '0;
    req_kind = 2'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_four_4k();
    t_upper_ignored();
    t_large();
    t_ps_top();
    t_not_present();
    t_rights();
    t_mode_refused();
    t_same_cycle();
    t_stray_and_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule